// File: doc/BRIEF.md
# Memory Module Presence-Detect Image Builder

This block builds the 256-byte presence-detect image that describes a synchronous DRAM module. A type code and a module size in megabytes are sampled on a start pulse. A short sequential pass then runs. It works out how the capacity is split into banks, finds the per-bank row density, and packs that density into the layout used for the chosen type. A second pass folds the first 63 bytes into a checksum.

The image is not held in a memory. Each byte is produced from a handful of registered fields, and a read port returns the byte at any address. A serial EEPROM target would normally sit in front of this port. Requests the block cannot represent raise an error flag, and the image then reads as zero.

Top module: `spd_image_gen`

## Requirements
- R1: After a successful build, the fixed bytes read as follows: 0:128, 1:8, 3:13, 4:10, 6:64, 8:4, 9:0x25, 10:1, 12:0x82, 13:8, 16:12, 17:4, 18:12, 20:2, 23:0x12, 27:20, 28:15, 29:20, 30:45, 32:20, 33:8, 34:20, 35:8. Every address not named in any requirement reads 0.
- R2: The accepted type codes are 4 (SDR), 7 (DDR) and 8 (DDR2). Byte 2 returns the sampled code unchanged.
- R3: The per-bank size is tracked as a log2 value in MB. It starts at log2 of the module size, with one bank. While it exceeds the type maximum (9 for SDR, 12 for DDR, 14 for DDR2) and there are fewer than 8 banks, it drops by one and the bank count doubles. Each such step takes one clock.
- R4: If one bank remains afterwards and the log2 value is above the type minimum (2 for SDR, 5 for DDR, 7 for DDR2), it drops by one and the bank count becomes 2.
- R5: Byte 5 holds the bank count minus one for DDR2, and the bank count for the other types.
- R6: Byte 31 holds the packed density. Let d = 1 << (log2 − 2) as a 16-bit value. DDR2 stores (d & 0xE0) | ((d >> 8) & 0x1F). DDR stores (d & 0xF8) | ((d >> 8) & 0x07). SDR stores d & 0xFF.
- R7: For DDR2, bytes 15, 19 and 21 read 0. For the other types, bytes 15 and 19 read 1 and byte 21 reads 0x20.
- R8: Byte 63 holds the sum, modulo 256, of bytes 0 through 62.
- R9: A build is rejected in any of these cases: the size is not a power of two, the type code is unknown, the log2 size is below the type minimum, or the log2 size is above the type maximum plus 3. On rejection, done and err are both high right after the start edge, and every address reads 0.
- R10: done falls at the start edge. It rises S+65 clock edges after the start edge, where S is the number of R3 steps. While it is low, every address reads 0.
- R11: A start pulse during a build is ignored. The build in progress finishes with its own inputs and its own timing.
- R12: After reset, done and err are low and the read port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Samples type and size and begins a build when idle |
| type_code | input | 8 | Memory type code (4, 7 or 8) |
| size_mb | input | SIZE_W | Module size in megabytes |
| rd_addr | input | 8 | Image byte address |
| rd_data | output | 8 | Image byte at rd_addr |
| done | output | 1 | Image is complete (level) |
| err | output | 1 | Last request was rejected |

## Verification
A wrong bank count or log2 value is visible at bytes 5 and 31 once done rises. It also changes byte 63, because the checksum is summed over live fields. A miscounted bank loop shifts the edge on which done rises by exactly the number of extra or missing steps, so the bench checks that edge count for every case. A state or index fault during the checksum walk shows only in byte 63, so every case reads all 256 addresses and compares them with a model built from the requirements.

// File: rtl/spd_image_gen.sv
module spd_image_gen #(
  parameter int SIZE_W = 18,
  parameter logic [7:0] T_SDR  = 8'd4,
  parameter logic [7:0] T_DDR  = 8'd7,
  parameter logic [7:0] T_DDR2 = 8'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        type_code,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              err
);
  localparam int L2_W = $clog2(SIZE_W + 4);

  typedef enum logic [1:0] {S_IDLE, S_BANK, S_SPLIT, S_SUM} st_t;
  st_t state;

  logic [7:0]      type_r;
  logic [L2_W-1:0] l2_r;
  logic [3:0]      banks_r;
  logic [5:0]      idx;
  logic [7:0]      cksum;

  function automatic logic [L2_W-1:0] lim_min(input logic [7:0] t);
    case (t)
      T_SDR:   return L2_W'(2);
      T_DDR:   return L2_W'(5);
      default: return L2_W'(7);
    endcase
  endfunction

  function automatic logic [L2_W-1:0] lim_max(input logic [7:0] t);
    case (t)
      T_SDR:   return L2_W'(9);
      T_DDR:   return L2_W'(12);
      default: return L2_W'(14);
    endcase
  endfunction

  function automatic logic [7:0] img_byte(input logic [7:0] a, input logic [7:0] t,
                                          input logic [3:0] bk, input logic [L2_W-1:0] l2,
                                          input logic [7:0] ck);
    logic [15:0] d;
    logic        ddr2;
    ddr2 = (t == T_DDR2);
    d    = 16'd1 << (l2 - L2_W'(2));
    case (a)
      8'd0:  return 8'd128;
      8'd1:  return 8'd8;
      8'd2:  return t;
      8'd3:  return 8'd13;
      8'd4:  return 8'd10;
      8'd5:  return ddr2 ? {4'd0, bk - 4'd1} : {4'd0, bk};
      8'd6:  return 8'd64;
      8'd8:  return 8'd4;
      8'd9:  return 8'h25;
      8'd10: return 8'd1;
      8'd12: return 8'h82;
      8'd13: return 8'd8;
      8'd15: return ddr2 ? 8'd0 : 8'd1;
      8'd16: return 8'd12;
      8'd17: return 8'd4;
      8'd18: return 8'd12;
      8'd19: return ddr2 ? 8'd0 : 8'd1;
      8'd20: return 8'd2;
      8'd21: return ddr2 ? 8'd0 : 8'h20;
      8'd23: return 8'h12;
      8'd27: return 8'd20;
      8'd28: return 8'd15;
      8'd29: return 8'd20;
      8'd30: return 8'd45;
      8'd31: begin
        if (ddr2)            return (d[7:0] & 8'hE0) | (d[15:8] & 8'h1F);
        else if (t == T_DDR) return (d[7:0] & 8'hF8) | (d[15:8] & 8'h07);
        else                 return d[7:0];
      end
      8'd32: return 8'd20;
      8'd33: return 8'd8;
      8'd34: return 8'd20;
      8'd35: return 8'd8;
      8'd63: return ck;
      default: return 8'd0;
    endcase
  endfunction

  logic [L2_W-1:0] l2_in;
  always_comb begin
    l2_in = '0;
    for (int i = 0; i < SIZE_W; i++)
      if (size_mb[i]) l2_in = L2_W'(i);
  end

  logic type_ok, pow2, bad_in;
  assign type_ok = (type_code == T_SDR) || (type_code == T_DDR) || (type_code == T_DDR2);
  assign pow2    = ($countones(size_mb) == 1);
  assign bad_in  = !type_ok || !pow2 || (l2_in < lim_min(type_code)) ||
                   (l2_in > lim_max(type_code) + L2_W'(3));

  logic [7:0] sum_byte;
  assign sum_byte = img_byte({2'b00, idx}, type_r, banks_r, l2_r, cksum);
  assign rd_data  = (done && !err) ? img_byte(rd_addr, type_r, banks_r, l2_r, cksum) : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      err     <= 1'b0;
      type_r  <= '0;
      l2_r    <= '0;
      banks_r <= 4'd1;
      idx     <= '0;
      cksum   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          type_r  <= type_code;
          l2_r    <= l2_in;
          banks_r <= 4'd1;
          done    <= bad_in;
          err     <= bad_in;
          state   <= bad_in ? S_IDLE : S_BANK;
        end
        S_BANK: begin
          if (l2_r > lim_max(type_r) && banks_r != 4'd8) begin
            l2_r    <= l2_r - L2_W'(1);
            banks_r <= banks_r << 1;
          end else begin
            state <= S_SPLIT;
          end
        end
        S_SPLIT: begin
          if (banks_r == 4'd1 && l2_r > lim_min(type_r)) begin
            l2_r    <= l2_r - L2_W'(1);
            banks_r <= 4'd2;
          end
          idx   <= '0;
          cksum <= '0;
          state <= S_SUM;
        end
        default: begin
          cksum <= cksum + sum_byte;
          idx   <= idx + 6'd1;
          if (idx == 6'd62) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R3
  bank_pow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(banks_r) == 1);

  // R3
  bank_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (l2_r <= lim_max(type_r)));

  // R4
  split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> !(banks_r == 4'd1 && l2_r > lim_min(type_r)));

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rd_data == 8'd0));

  // R10
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> !done);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(type_r));
endmodule

// File: tb/spd_image_gen_bench.sv
module spd_image_gen_bench;
  localparam int CLK_P  = 10;
  localparam int SIZE_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [7:0]        type_code = 8'd4;
  logic [SIZE_W-1:0] size_mb = '0;
  logic [7:0]        rd_addr = '0;
  logic [7:0]        rd_data;
  logic              done, err;

  int total = 0;
  int bad   = 0;

  spd_image_gen #(.SIZE_W(SIZE_W)) u_spd_image_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .type_code(type_code),
    .size_mb(size_mb), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .err(err));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int tmin(input int t);
    return (t == 4) ? 2 : (t == 7) ? 5 : 7;
  endfunction
  function automatic int tmax(input int t);
    return (t == 4) ? 9 : (t == 7) ? 12 : 14;
  endfunction

  function automatic int exp_byte(input int a, input int t, input int bk, input int l2, input int ck);
    int d;
    bit d2;
    d2 = (t == 8);
    d  = (1 << (l2 - 2)) & 16'hFFFF;
    case (a)
      0: return 128;   1: return 8;     2: return t;     3: return 13;
      4: return 10;    5: return d2 ? bk - 1 : bk;       6: return 64;
      8: return 4;     9: return 'h25;  10: return 1;    12: return 'h82;
      13: return 8;    15: return d2 ? 0 : 1;            16: return 12;
      17: return 4;    18: return 12;   19: return d2 ? 0 : 1;
      20: return 2;    21: return d2 ? 0 : 'h20;         23: return 'h12;
      27: return 20;   28: return 15;   29: return 20;   30: return 45;
      31: begin
        if (d2)          return (d & 'hE0) | ((d >> 8) & 'h1F);
        else if (t == 7) return (d & 'hF8) | ((d >> 8) & 'h07);
        else             return d & 'hFF;
      end
      32: return 20;   33: return 8;    34: return 20;   35: return 8;
      63: return ck;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      2: return "R2";
      5: return "R3/R4/R5";
      31: return "R6";
      15, 19, 21: return "R7";
      63: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic run_case(input int t, input int sz, input bit inject);
    bit rej;
    int l2, bk, steps, ck, cnt;
    l2 = 0;
    for (int i = 0; i < SIZE_W; i++) if (sz[i]) l2 = i;
    rej = ($countones(sz[SIZE_W-1:0]) != 1) || !(t == 4 || t == 7 || t == 8) ||
          (l2 < tmin(t)) || (l2 > tmax(t) + 3);
    bk = 1; steps = 0;
    if (!rej) begin
      while (l2 > tmax(t) && bk < 8) begin l2--; bk *= 2; steps++; end
      if (bk == 1 && l2 > tmin(t)) begin l2--; bk = 2; end
    end
    ck = 0;
    for (int a = 0; a < 63; a++) ck = (ck + exp_byte(a, t, bk, l2, 0)) & 255;

    @(negedge clk);
    type_code = 8'(t); size_mb = SIZE_W'(sz); start = 1'b1; rd_addr = 8'd0;
    @(posedge clk); #1 start = 1'b0;
    cnt = 0;
    while (!done && cnt < 500) begin
      @(posedge clk); #1;
      cnt++;
      if (cnt == 1 && !done) check("R10 read zero while busy", rd_data, 0);
      if (inject && cnt == 3) begin
        type_code = (t == 4) ? 8'd8 : 8'd4;
        size_mb = SIZE_W'(1 << 9);
        start = 1'b1;
      end
      if (inject && cnt == 4) start = 1'b0;
    end
    if (rej) begin
      check("R9 immediate done", cnt, 0);
      check("R9 err flag", err, 1);
      for (int a = 0; a < 256; a += 37) begin
        rd_addr = 8'(a); #1;
        check("R9 zero image", rd_data, 0);
      end
    end else begin
      check(inject ? "R11 latency" : "R10 latency", cnt, steps + 65);
      check("R9 no err", err, 0);
      for (int a = 0; a < 256; a++) begin
        rd_addr = 8'(a); #1;
        check(inject ? "R11 image" : tag_of(a), rd_data, exp_byte(a, t, bk, l2, ck));
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int types[3];
    int t, l2, sz;
    void'($urandom(32'd1234));
    types[0] = 4; types[1] = 7; types[2] = 8;
    #(CLK_P * 3);
    check("R12 done after reset", done, 0);
    check("R12 err after reset", err, 0);
    check("R12 rd_data after reset", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;

    run_case(4, 4, 0);
    run_case(4, 8, 0);
    run_case(4, 512, 0);
    run_case(4, 1024, 0);
    run_case(4, 4096, 0);
    run_case(4, 8192, 0);
    run_case(4, 2, 0);
    run_case(4, 6, 0);
    run_case(4, 0, 0);
    run_case(7, 32, 0);
    run_case(7, 1 << 15, 0);
    run_case(8, 128, 0);
    run_case(8, 1 << 17, 0);
    run_case(8, 1 << 16, 0);
    run_case(5, 256, 0);
    run_case(7, 1 << 13, 1);
    run_case(8, 256, 1);

    for (int n = 0; n < 40; n++) begin
      t  = types[$urandom_range(0, 2)];
      l2 = $urandom_range(0, SIZE_W - 1);
      sz = 1 << l2;
      if ($urandom_range(0, 7) == 0) sz = sz | 1 | (1 << $urandom_range(1, SIZE_W - 1));
      if ($urandom_range(0, 15) == 0) t = $urandom_range(0, 15);
      run_case(t, sz, $urandom_range(0, 5) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule